// File: doc/BRIEF.md
# Escape-aware two-wire deserializing receiver

This block receives a self-timed two-wire serial stream and rebuilds 32-bit packets from it. One wire carries the data level, the other a phase wire. A new data bit is signalled by toggling exactly one wire. If the new bit differs from the data wire's current level, the data wire toggles. If the bit repeats, the phase wire toggles. Both lines are brought into the local clock domain through two-flop synchronizers. Every change seen on either wire is one symbol. A symbol that toggles both wires at once is an escape.

Runs of identical bits arrive in compressed form. An escape opens the run. Five length bits follow, most significant bit first. A second escape closes the run. The receiver has three states: counting, length decoding and bulk write. In the bulk write state a range decoder enables every packet cell from the current fill index up to index plus length minus one, in a single clock cycle. All of those cells get the most recently stored data bit. Ordinary bits are stored one cell at a time. A one-cycle `packet_valid` pulse marks each complete packet.

Top module: `ledr_escape_rx`

## Requirements
- R1: After reset, `packet` is all zeros and `packet_valid` is low.
- R2: A symbol that toggles only one wire stores the new level of `s_in` into `packet` bit N. N is the fill index, which starts at 0 and rises by one per stored bit. Bit 0 holds the first bit of a packet.
- R3: When bit 31 has been stored, `packet_valid` pulses and the fill index returns to 0. At that pulse `packet` holds the complete packet.
- R4: The compressed-run sequence is: an escape (both wires toggle), five single-wire length symbols (MSB first, value L taken from `s_in`), then an escape. This sequence stores L copies of the last stored data bit into bits N to N+L-1. The fill index then continues at N+L.
- R5: The length symbols and both escapes are never stored as data bits.
- R6: A run of length 0 stores nothing and leaves the fill index unchanged.
- R7: A run that reaches or passes bit 31 fills the cells up to bit 31 and drops the rest. It then pulses `packet_valid`, and the next bit goes to bit 0.
- R8: The run value carries across a packet boundary. A run at the start of a packet repeats the last data bit of the previous packet, and it repeats 0 after reset.
- R9: `packet_valid` is never high for two consecutive cycles.
- R10: While neither wire changes, `packet` keeps its value, however long the line stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| s_in | input | 1 | Data-level wire, asynchronous |
| p_in | input | 1 | Phase wire, asynchronous |
| packet | output | 32 | Packet storage register, complete when `packet_valid` is high |
| packet_valid | output | 1 | One-cycle pulse when the packet is full |

## Verification
The bench sends runs of length zero, length 31 and lengths that spill past bit 31. A design that mishandles the range would write one cell too many or too few, or would wrap the spill into the next packet's low bits. It also sends runs at the very start of a packet, which a design that resets the run value at the boundary would fill with the wrong level. Long runs of repeated bits are encoded only by phase-wire toggles, which catches a design that takes the phase wire as the data. Length codes that mix ones and zeros expose any design that stores length symbols as data, and idle gaps in mid-packet expose spurious events.

// File: rtl/ledr_rx_pkg.sv
package ledr_rx_pkg;

    localparam int PKT_W       = 32;
    localparam int LEN_W       = 5;
    localparam int IDX_W       = $clog2(PKT_W);
    localparam int NL_W        = $clog2(LEN_W);
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_COUNT  = 2'd0,
        ST_DECODE = 2'd1,
        ST_WRITE  = 2'd2
    } rx_state_e;

    // one detected line symbol
    typedef struct packed {
        logic hit;   // any wire changed
        logic esc;   // both wires changed
        logic s;     // current data-wire level
    } sym_t;

    // write command from controller to storage
    typedef struct packed {
        logic             single;
        logic             bulk;
        logic [IDX_W-1:0] idx;
        logic [IDX_W:0]   lo;
        logic [IDX_W:0]   hi_excl;
        logic             val;
    } wr_cmd_t;

    function automatic logic in_span(input int i,
                                     input logic [IDX_W:0] lo,
                                     input logic [IDX_W:0] hi_excl);
        logic [IDX_W:0] pos;
        pos = (IDX_W+1)'(i);
        return (pos >= lo) && (pos < hi_excl);
    endfunction

endpackage

// File: rtl/ledr_rx_sync.sv
module ledr_rx_sync
    import ledr_rx_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic s_in,
    input  logic p_in,
    output sym_t sym
);
    logic [1:0] lanes_in;
    logic [1:0] cur;
    logic [1:0] prev;
    logic [1:0] chg;

    assign lanes_in = {p_in, s_in};

    generate
        for (genvar l = 0; l < 2; l++) begin : g_lane
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-2:0], lanes_in[l]};
            end
            assign cur[l] = sh[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= cur;
    end

    always_comb begin
        chg     = cur ^ prev;
        sym.hit = |chg;
        sym.esc = &chg;
        sym.s   = cur[0];
    end

endmodule

// File: rtl/ledr_rx_ctrl.sv
module ledr_rx_ctrl
    import ledr_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  sym_t    sym,
    output wr_cmd_t cmd,
    output logic    pkt_valid
);
    rx_state_e        state;
    logic [IDX_W-1:0] cnt;
    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] len_next;
    logic [NL_W-1:0]  nlen;
    logic             last_bit;
    logic             go;
    logic [IDX_W:0]   span_lo;
    logic [IDX_W:0]   span_hi;
    logic             norm;

    assign norm     = sym.hit && !sym.esc;
    assign len_next = {len[LEN_W-2:0], sym.s};

    always_comb begin
        cmd.single  = (state == ST_COUNT) && norm;
        cmd.bulk    = (state == ST_WRITE) && go;
        cmd.idx     = cnt;
        cmd.lo      = span_lo;
        cmd.hi_excl = span_hi;
        cmd.val     = cmd.single ? sym.s : last_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_COUNT;
            cnt       <= '0;
            len       <= '0;
            nlen      <= '0;
            last_bit  <= 1'b0;
            go        <= 1'b0;
            span_lo   <= '0;
            span_hi   <= '0;
            pkt_valid <= 1'b0;
        end else begin
            pkt_valid <= 1'b0;
            case (state)
                ST_COUNT: begin
                    if (sym.hit && sym.esc) begin
                        state <= ST_DECODE;
                        len   <= '0;
                        nlen  <= '0;
                    end else if (norm) begin
                        last_bit <= sym.s;
                        if (cnt == IDX_W'(PKT_W-1)) begin
                            cnt       <= '0;
                            pkt_valid <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_DECODE: begin
                    if (norm) begin
                        len <= len_next;
                        if (nlen == NL_W'(LEN_W-1)) begin
                            state   <= ST_WRITE;
                            go      <= 1'b1;
                            span_lo <= {1'b0, cnt};
                            span_hi <= {1'b0, cnt} + (IDX_W+1)'(len_next);
                        end else begin
                            nlen <= nlen + 1'b1;
                        end
                    end
                end
                ST_WRITE: begin
                    if (go) begin
                        go <= 1'b0;
                        if (span_hi >= (IDX_W+1)'(PKT_W)) begin
                            cnt       <= '0;
                            pkt_valid <= 1'b1;
                        end else begin
                            cnt <= span_hi[IDX_W-1:0];
                        end
                    end
                    if (sym.hit) state <= ST_COUNT;
                end
                default: state <= ST_COUNT;
            endcase
        end
    end

    // R9: completion pulse lasts one cycle
    a_r9_valid_single: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |=> !pkt_valid);

    // R4: an escape while counting opens length decoding
    a_r4_escape_opens: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT && sym.hit && sym.esc) |=> (state == ST_DECODE));

    // R4: a bulk write lasts exactly one cycle
    a_r4_bulk_once: assert property (@(posedge clk) disable iff (rst)
        cmd.bulk |=> !cmd.bulk);

endmodule

// File: rtl/ledr_rx_store.sv
module ledr_rx_store
    import ledr_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wr_cmd_t          cmd,
    output logic [PKT_W-1:0] word
);
    logic [PKT_W-1:0] en;

    generate
        for (genvar i = 0; i < PKT_W; i++) begin : g_cell
            assign en[i] = (cmd.single && (cmd.idx == IDX_W'(i)))
                        || (cmd.bulk && in_span(i, cmd.lo, cmd.hi_excl));
            always_ff @(posedge clk) begin
                if (rst)        word[i] <= 1'b0;
                else if (en[i]) word[i] <= cmd.val;
            end
        end
    endgenerate

    // R2: a single write enables exactly one cell
    a_r2_single_cell: assert property (@(posedge clk) disable iff (rst)
        cmd.single |-> $onehot(en));

    // R5: no command, no enabled cell
    a_r5_idle_no_enable: assert property (@(posedge clk) disable iff (rst)
        (!cmd.single && !cmd.bulk) |-> (en == '0));

endmodule

// File: rtl/ledr_escape_rx.sv
module ledr_escape_rx
    import ledr_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             s_in,
    input  logic             p_in,
    output logic [PKT_W-1:0] packet,
    output logic             packet_valid
);
    sym_t    sym;
    wr_cmd_t cmd;

    ledr_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .s_in(s_in),
        .p_in(p_in),
        .sym (sym)
    );

    ledr_rx_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sym      (sym),
        .cmd      (cmd),
        .pkt_valid(packet_valid)
    );

    ledr_rx_store u_store (
        .clk (clk),
        .rst (rst),
        .cmd (cmd),
        .word(packet)
    );

    // R10: without a line change or a pending bulk write the packet holds
    a_r10_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        (!sym.hit && !cmd.bulk) |=> $stable(packet));

endmodule

// File: tb/ledr_escape_rx_test.sv
module ledr_escape_rx_test;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 4;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_in = 1'b0;
    logic        p_in = 1'b0;
    logic [31:0] packet;
    logic        packet_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    logic        cs = 1'b0;
    logic        cp = 1'b0;
    logic [31:0] mword = '0;
    int          midx  = 0;
    logic        mlast = 1'b0;
    logic        prev_v = 1'b0;

    ledr_escape_rx uut (
        .clk         (clk),
        .rst         (rst),
        .s_in        (s_in),
        .p_in        (p_in),
        .packet      (packet),
        .packet_valid(packet_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_sym(input logic ns, input logic np);
        @(negedge clk);
        s_in = ns; p_in = np; cs = ns; cp = np;
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic raw_bit(input logic b);
        if (b != cs) drive_sym(~cs, cp);
        else         drive_sym(cs, ~cp);
    endtask

    task automatic raw_esc();
        drive_sym(~cs, ~cp);
    endtask

    task automatic model_put(input logic b, input string tag);
        mword[midx] = b;
        midx++;
        if (midx == 32) begin
            exp_q.push_back(mword);
            tag_q.push_back(tag);
            midx = 0;
        end
    endtask

    task automatic data_bit(input logic b, input string tag);
        model_put(b, tag);
        mlast = b;
        raw_bit(b);
    endtask

    task automatic bits(input logic [31:0] v, input int n, input string tag);
        for (int i = 0; i < n; i++) data_bit(v[i], tag);
    endtask

    task automatic run(input int len, input string tag);
        logic [4:0] l5;
        l5 = 5'(len);
        for (int k = 0; k < len; k++) begin
            model_put(mlast, tag);
            if (midx == 0) break;   // spill past bit 31 is dropped
        end
        raw_esc();
        for (int k = 4; k >= 0; k--) raw_bit(l5[k]);
        raw_esc();
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (packet_valid) begin
                if (prev_v) begin
                    check(1'b0, "R9 valid held two cycles", 32'd1, 32'd0);
                end else if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected packet_valid", packet, 32'd0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(packet == e, t, packet, e);
                end
            end
            prev_v = packet_valid;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check(packet == 32'd0, "R1 packet after reset", packet, 32'd0);
        check(packet_valid == 1'b0, "R1 valid after reset", 32'(packet_valid), 32'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R8: run at very start repeats 0 after reset
        run(3, "R8 start after reset");
        bits(32'h1234_5679, 29, "R2 R3 plain bits");
        // R2: mixed pattern
        bits(32'hA5C3_0F96, 32, "R2 mixed pattern");
        // R2: repeated bits carried only on phase wire
        bits(32'hFFFF_FFFF, 32, "R2 phase-only repeats");
        // R4 R5: run of 10 with mixed length code
        bits(32'h0000_0005, 3, "R4 R5 run of ten");
        run(10, "R4 R5 run of ten");
        bits(32'h0005_2A4B, 19, "R4 R5 run of ten");
        // R6: zero-length run
        bits(32'h0000_0003, 2, "R6 zero run");
        run(0, "R6 zero run");
        bits(32'h9ABC_DEF0, 30, "R6 zero run");
        // R7: spill past bit 31
        bits(32'h0C35_A96E, 28, "R7 spill");
        run(9, "R7 spill");
        // R8: run at packet start uses previous packet's last data bit
        run(5, "R8 carry across boundary");
        bits(32'h0471_3B2D, 27, "R8 carry across boundary");
        // R7: run ending exactly at bit 31 (length 31)
        data_bit(1'b1, "R7 exact fill");
        run(31, "R7 exact fill");
        // R10: idle gaps inside a packet with two runs
        repeat (60) @(negedge clk);
        bits(32'h0000_0006, 4, "R10 idle gaps");
        run(3, "R10 idle gaps");
        repeat (40) @(negedge clk);
        bits(32'h0000_0009, 4, "R10 idle gaps");
        run(6, "R10 idle gaps");
        repeat (25) @(negedge clk);
        bits(32'h0000_5A3C, 15, "R10 idle gaps");

        repeat (30) @(negedge clk);
        // R3: every expected packet was delivered
        check(exp_q.size() == 0, "R3 packets outstanding",
              32'(exp_q.size()), 32'd0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule